// File: doc/BRIEF.md
# Speculative Fast Address Generator

This block forms a load/store effective address from a base operand and an index operand. It has two outputs. A speculative address appears combinationally in the same cycle, so a cache pipeline can start its lookup before a full-width carry has resolved. The exact sum follows one register later, together with a mispredict flag. When the flag is set, the downstream pipeline must replay the access with the exact address.

There are two early modes. The first is a bitwise OR of the operands, which is exact whenever the operands share no set bit. The second is a segmented adder in which carries never leave a segment of `SEG_W` bits. A third setting turns speculation off and presents the full sum on the fast output.

A new request can be accepted on every cycle. A mispredict never stalls the input side; it only marks the result of the request it belongs to.

Top module: `spec_agen`

## Requirements
- R1: `exact_addr_o` equals (`base_i` + `index_i`) modulo 2^`ADDR_W`, taken from the request accepted on the previous rising clock edge.
- R2: `exact_valid_o` equals the `valid_i` of the previous cycle. After reset, `exact_valid_o`, `exact_addr_o` and `mispredict_o` are all 0.
- R3: With `mode_i` = 2'b00 (no speculation), `fast_addr_o` equals the full sum in the same cycle, and the registered `mispredict_o` is 0.
- R4: With `mode_i` = 2'b01 (OR mode), `fast_addr_o` equals `base_i | index_i` in the same cycle.
- R5: In OR mode, the registered `mispredict_o` equals the reduction OR of (`base_i & index_i`).
- R6: With `mode_i` = 2'b10 (segmented mode), `fast_addr_o` is formed from segments of `SEG_W` bits, counted from bit 0. Each segment is the sum of that segment's operand slices with carry-in 0, and any carry out of a segment is dropped. The top segment holds the remaining bits and may be narrower than `SEG_W`.
- R7: In segmented mode, the registered `mispredict_o` is 1 exactly when the segmented address differs from the full sum.
- R8: `mode_i` = 2'b11 behaves identically to 2'b00.
- R9: `mispredict_o` is asserted only together with `exact_valid_o`. In a cycle with no accepted request, `exact_addr_o` holds its previous value.
- R10: A request is accepted on every cycle in which `valid_i` is 1, including back-to-back cycles. `exact_addr_o` and `mispredict_o` always describe the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | 00 exact, 01 OR, 10 segmented, 11 exact |
| base_i | input | ADDR_W | Base operand |
| index_i | input | ADDR_W | Index operand |
| fast_addr_o | output | ADDR_W | Speculative address, same cycle |
| exact_addr_o | output | ADDR_W | Registered full sum |
| exact_valid_o | output | 1 | Registered request strobe |
| mispredict_o | output | 1 | Registered replay flag for the request shown |

## Verification
The bench uses a 6-bit configuration with 4-bit segments. It sweeps every base/index pair under all four mode codes, so the top segment is a narrower 2-bit slice.

The OR sweep covers the disjoint operand pairs that must not replay and the overlapping pairs that must. The segmented sweep covers carries confined to one segment, carries that cross the boundary at bit 4, and carries out of the top segment, which must not flag a mispredict because the full sum also drops them.

Requests arrive back-to-back, with idle cycles mixed in, to check that results line up with their requests and that the exact output holds while idle.

// File: rtl/spec_agen_pkg.sv
package spec_agen_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT = 2'b00,
    MODE_OR    = 2'b01,
    MODE_SEG   = 2'b10,
    MODE_RSVD  = 2'b11
  } agen_mode_e;
endpackage

// File: rtl/spec_agen_or.sv
module spec_agen_or #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              miss_o
);
  assign addr_o = a_i | b_i;
  // any shared set bit would have produced a carry
  assign miss_o = |(a_i & b_i);
endmodule

// File: rtl/spec_agen_seg.sv
module spec_agen_seg #(
  parameter int ADDR_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  input  logic [ADDR_W-1:0] full_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              miss_o
);
  localparam int NSEG = (ADDR_W + SEG_W - 1) / SEG_W;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    localparam int HI = ((LO + SEG_W) > ADDR_W) ? ADDR_W - 1 : LO + SEG_W - 1;
    assign addr_o[HI:LO] = a_i[HI:LO] + b_i[HI:LO];
  end

  assign miss_o = (addr_o != full_i);
endmodule

// File: rtl/spec_agen_stage.sv
module spec_agen_stage #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] sum_i,
  input  logic              miss_i,
  output logic [ADDR_W-1:0] sum_o,
  output logic              valid_o,
  output logic              miss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      valid_o <= 1'b0;
      miss_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      miss_o  <= valid_i & miss_i;
      if (valid_i) sum_o <= sum_i;
    end
  end
endmodule

// File: rtl/spec_agen.sv
module spec_agen
  import spec_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] fast_addr_o,
  output logic [ADDR_W-1:0] exact_addr_o,
  output logic              exact_valid_o,
  output logic              mispredict_o
);
  agen_mode_e        mode;
  logic [ADDR_W-1:0] full_sum, or_addr, seg_addr;
  logic              or_miss, seg_miss, miss_sel;

  assign mode     = agen_mode_e'(mode_i);
  assign full_sum = base_i + index_i;

  spec_agen_or #(.ADDR_W(ADDR_W)) u_or (
    .a_i(base_i), .b_i(index_i), .addr_o(or_addr), .miss_o(or_miss)
  );

  spec_agen_seg #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_seg (
    .a_i(base_i), .b_i(index_i), .full_i(full_sum),
    .addr_o(seg_addr), .miss_o(seg_miss)
  );

  always_comb begin
    case (mode)
      MODE_OR:  begin fast_addr_o = or_addr;  miss_sel = or_miss;  end
      MODE_SEG: begin fast_addr_o = seg_addr; miss_sel = seg_miss; end
      default:  begin fast_addr_o = full_sum; miss_sel = 1'b0;     end
    endcase
  end

  spec_agen_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .sum_i(full_sum), .miss_i(miss_sel),
    .sum_o(exact_addr_o), .valid_o(exact_valid_o), .miss_o(mispredict_o)
  );
endmodule

// File: rtl/spec_agen_chk.sv
module spec_agen_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] index_i,
  input logic [ADDR_W-1:0] exact_addr_o,
  input logic              exact_valid_o,
  input logic              mispredict_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  a_r1_exact_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(valid_i) |->
      exact_addr_o == ADDR_W'($past(base_i) + $past(index_i)));

  a_r2_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> exact_valid_o == $past(valid_i));

  a_r3_exact_no_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(valid_i) && $past(mode_i) == 2'b00 |-> !mispredict_o);

  a_r5_or_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(valid_i) && $past(mode_i) == 2'b01 |->
      mispredict_o == |($past(base_i) & $past(index_i)));

  a_r8_rsvd_no_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(valid_i) && $past(mode_i) == 2'b11 |-> !mispredict_o);

  a_r9_miss_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> exact_valid_o);

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && !$past(valid_i) |-> $stable(exact_addr_o));
endmodule

bind spec_agen spec_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .base_i(base_i), .index_i(index_i), .exact_addr_o(exact_addr_o),
  .exact_valid_o(exact_valid_o), .mispredict_o(mispredict_o)
);

// File: tb/spec_agen_bench.sv
module spec_agen_bench;
  localparam int W = 6;
  localparam int SEG = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] base = '0, index = '0;
  logic [W-1:0] fast_addr, exact_addr;
  logic         exact_valid, mispredict;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_agen #(.ADDR_W(W), .SEG_W(SEG)) u_spec_agen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .base_i(base), .index_i(index), .fast_addr_o(fast_addr),
    .exact_addr_o(exact_addr), .exact_valid_o(exact_valid),
    .mispredict_o(mispredict)
  );

  function automatic logic [W-1:0] seg_model(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] s;
    logic c;
    c = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (k % SEG == 0) c = 1'b0;
      s[k] = a[k] ^ b[k] ^ c;
      c = (a[k] & b[k]) | (c & (a[k] ^ b[k]));
    end
    return s;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pending expectation from the previous request
  logic [W-1:0] p_sum = '0;
  logic         p_valid = 1'b0, p_miss = 1'b0;

  task automatic step(logic v, logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] sum, f;
    logic miss;
    @(negedge clk);
    check("R1 exact_addr", exact_addr, p_sum);
    check("R2 exact_valid", W'(exact_valid), W'(p_valid));
    check("R9 R10 mispredict", W'(mispredict), W'(p_miss));
    valid = v; mode = m; base = a; index = b;
    sum = a + b;
    case (m)
      2'b01:   begin f = a | b;           miss = |(a & b);  end
      2'b10:   begin f = seg_model(a, b); miss = (f != sum); end
      default: begin f = sum;             miss = 1'b0;      end
    endcase
    #1;
    case (m)
      2'b00: check("R3 fast exact", fast_addr, f);
      2'b01: check("R4 fast or", fast_addr, f);
      2'b10: check("R6 fast seg", fast_addr, f);
      default: check("R8 fast rsvd", fast_addr, f);
    endcase
    if (v) p_sum = sum;
    p_valid = v;
    p_miss  = v & miss;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset addr", exact_addr, '0);
    check("R2 reset valid", W'(exact_valid), '0);
    check("R2 reset miss", W'(mispredict), '0);
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        for (int m = 0; m < 4; m++)
          step(((a + b + m) % 5) != 0, 2'(m), W'(a), W'(b));
    // directed: top-segment carry out is dropped by both sums, no replay (R7)
    step(1'b1, 2'b10, 6'b110000, 6'b010000);
    step(1'b0, 2'b10, '0, '0);
    // boundary carry at bit 4 must replay (R7)
    step(1'b1, 2'b10, 6'b001111, 6'b000001);
    step(1'b0, 2'b00, '0, '0);
    done = 1'b1;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule